// File: doc/BRIEF.md
# Breakpoint and Debug-Mode Controller

This unit sits between a debug host link and a small processor core. The host writes and reads one 8-bit control word. The core reports every decoded breakpoint opcode with a one-cycle strobe. From the control word and that strobe, the unit produces three outputs for the core: a halt-fetch level, a loop-on-breakpoint level and a one-cycle system reset request. It also offers a single acknowledge byte of value 0xFF to a serial debug transmitter.

The host uses the control word as a command port. Writing 0x81 resets the system and leaves it halted. Writing 0x41 resets the system and lets it run with breakpoints armed. Writing 0x40 while halted resumes execution.

The acknowledge byte travels over a valid/ready handshake. Once `ack_valid` rises, it stays high and `ack_data` stays constant until a cycle in which `ack_ready` is also high. A transfer completes on a clock edge where both are high. The transmitter may hold `ack_ready` low for any number of cycles, and no byte is lost or duplicated while it does.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: After reset, `host_rdata` reads 0x00 and `halt_fetch`, `loop_brk`, `sys_reset_req` and `ack_valid` are all low.
- R2: A host write stores bits 7, 6, 5, 4, 3 and 2, and they read back unchanged. Bit 1 always reads 0, whatever was written to it.
- R3: `halt_fetch` follows control bit 7 (halt). Writing 0x40 while halted clears the halt bit and resumes fetching.
- R4: While bit 6 (arm) is 0, a breakpoint strobe has no effect. The control word, `halt_fetch`, `loop_brk` and `ack_valid` stay as they were.
- R5: When arm=1 and bit 4 (loop) is 0, a breakpoint strobe sets the halt bit on the next clock edge.
- R6: When arm=1 and loop=1, `loop_brk` is high in the same cycle as the breakpoint strobe, and the halt bit is left unchanged.
- R7: Writing bit 0 (reset) as 1 raises `sys_reset_req` for exactly the one cycle after the write. Bit 0 reads 1 in that cycle and 0 afterwards. A write of 0x81 leaves the word at 0x80, and a write of 0x41 leaves it at 0x40.
- R8: A breakpoint taken while arm=1 and bit 5 (ack enable) is 1 raises `ack_valid` on the next edge, with `ack_data` = 0xFF. Both stay stable while `ack_ready` is low.
- R9: On the edge that completes the handshake, `ack_valid` falls and bit 5 clears itself.
- R10: Further breakpoints taken while a byte is still pending do not queue another byte. Exactly one byte is transferred per enabled acknowledge.
- R11: When a breakpoint strobe with arm=1 and loop=0 coincides with a host write, the halt bit is set regardless of the written value. All other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 8 | Value written by the host |
| host_rdata | output | 8 | Current control word |
| brk_decoded | input | 1 | One-cycle strobe: breakpoint opcode decoded |
| halt_fetch | output | 1 | Core must not fetch new instructions |
| loop_brk | output | 1 | Core re-executes the current breakpoint opcode |
| sys_reset_req | output | 1 | One-cycle system reset request |
| ack_valid | output | 1 | Acknowledge byte offered |
| ack_data | output | 8 | Acknowledge byte (0xFF) |
| ack_ready | input | 1 | Transmitter accepts the byte |

## Verification
The breakpoint strobe is tried with arm=0, with arm and loop=0, and with arm and loop=1. These three cases tell the no-effect path apart from entry into halt and from the looping path. The strobe is also applied in the same cycle as a host write, which shows which source wins the halt bit. The three command codes, plus a write with the reserved bit set, show that the reset bit self-clears and that the reserved bit is masked. For the acknowledge path, the transmitter stalls, a second breakpoint arrives while a byte is pending, and a loop-mode burst of strobes follows. These show that the byte is held stable, sent once, and that bit 5 then clears.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int unsigned CTL_W     = 8;
  localparam int unsigned B_HALT    = 7;
  localparam int unsigned B_ARM     = 6;
  localparam int unsigned B_ACKEN   = 5;
  localparam int unsigned B_LOOP    = 4;
  localparam int unsigned B_PCM     = 3;
  localparam int unsigned B_ZRM     = 2;
  localparam int unsigned B_RSVD    = 1;
  localparam int unsigned B_RST     = 0;
  localparam logic [CTL_W-1:0] STORE_MASK = 8'hFD;

  typedef struct packed {
    logic halt;
    logic arm;
    logic acken;
    logic loop;
    logic pcm;
    logic zrm;
    logic rst;
  } ctl_t;
endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
  import dbg_brk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [CTL_W-1:0] host_wdata,
  input  logic             set_halt,
  input  logic             ack_done,
  output ctl_t             ctl,
  output logic [CTL_W-1:0] rdata
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d     = ctl_q;
    ctl_d.rst = 1'b0;
    if (ack_done) ctl_d.acken = 1'b0;
    if (host_wr) begin
      ctl_d.halt  = host_wdata[B_HALT];
      ctl_d.arm   = host_wdata[B_ARM];
      ctl_d.acken = host_wdata[B_ACKEN];
      ctl_d.loop  = host_wdata[B_LOOP];
      ctl_d.pcm   = host_wdata[B_PCM];
      ctl_d.zrm   = host_wdata[B_ZRM];
      ctl_d.rst   = host_wdata[B_RST];
    end
    if (set_halt) ctl_d.halt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;

  always_comb begin
    rdata         = '0;
    rdata[B_HALT] = ctl_q.halt;
    rdata[B_ARM]  = ctl_q.arm;
    rdata[B_ACKEN]= ctl_q.acken;
    rdata[B_LOOP] = ctl_q.loop;
    rdata[B_PCM]  = ctl_q.pcm;
    rdata[B_ZRM]  = ctl_q.zrm;
    rdata[B_RST]  = ctl_q.rst;
  end

  assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.rst && !host_wr) |=> !ctl_q.rst);
  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !set_halt) |=> ((rdata & STORE_MASK) == ($past(host_wdata) & STORE_MASK)));
endmodule

// File: rtl/dbg_brk_event.sv
module dbg_brk_event (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_decoded,
  input  logic arm,
  input  logic loop,
  input  logic halt,
  output logic hit,
  output logic set_halt,
  output logic loop_brk
);
  assign hit      = brk_decoded & arm;
  assign set_halt = hit & ~loop;
  assign loop_brk = hit & loop;

  assert_brk_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_decoded && arm && !loop) |=> halt);
  assert_loop_no_loopout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm) |-> !loop_brk);
endmodule

// File: rtl/dbg_ack_tx.sv
module dbg_ack_tx #(
  parameter int unsigned DATA_W   = 8,
  parameter logic [DATA_W-1:0] ACK_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              ack_en,
  input  logic              ack_ready,
  output logic              ack_valid,
  output logic [DATA_W-1:0] ack_data,
  output logic              ack_done
);
  logic pend_q;

  assign ack_done = pend_q & ack_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend_q <= 1'b0;
    else if (ack_done)                pend_q <= 1'b0;
    else if (hit && ack_en && !pend_q) pend_q <= 1'b1;
  end

  assign ack_valid = pend_q;
  assign ack_data  = pend_q ? ACK_BYTE : '0;

  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_data)));
  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready) |=> !ack_valid);
  assert_ack_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_data == ACK_BYTE));
endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] ACK_BYTE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [CTL_W-1:0]  host_wdata,
  output logic [CTL_W-1:0]  host_rdata,
  input  logic              brk_decoded,
  output logic              halt_fetch,
  output logic              loop_brk,
  output logic              sys_reset_req,
  output logic              ack_valid,
  output logic [DATA_W-1:0] ack_data,
  input  logic              ack_ready
);
  ctl_t ctl;
  logic hit, set_halt, ack_done;

  dbg_ctl_reg u_reg (
    .clk, .rst_n, .host_wr, .host_wdata,
    .set_halt, .ack_done, .ctl, .rdata(host_rdata)
  );

  dbg_brk_event u_evt (
    .clk, .rst_n, .brk_decoded,
    .arm(ctl.arm), .loop(ctl.loop), .halt(ctl.halt),
    .hit, .set_halt, .loop_brk
  );

  dbg_ack_tx #(.DATA_W(DATA_W), .ACK_BYTE(ACK_BYTE)) u_ack (
    .clk, .rst_n, .hit, .ack_en(ctl.acken), .ack_ready,
    .ack_valid, .ack_data, .ack_done
  );

  assign halt_fetch    = ctl.halt;
  assign sys_reset_req = ctl.rst;

  assert_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_decoded && !ctl.arm && !host_wr) |=> ($stable(halt_fetch) && !$rose(ack_valid)));
  assert_loop_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_decoded && ctl.arm && ctl.loop && !host_wr) |=> $stable(halt_fetch));
  assert_halt_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_decoded && ctl.arm && !ctl.loop && host_wr) |=> halt_fetch);
endmodule

// File: tb/test_dbg_brk_ctrl.sv
module test_dbg_brk_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       brk_decoded = 1'b0;
  logic       halt_fetch, loop_brk, sys_reset_req, ack_valid;
  logic [7:0] ack_data;
  logic       ack_ready = 1'b0;

  int n_chk = 0, n_err = 0, n_bytes = 0;
  bit finished = 0;
  logic lp_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_brk_ctrl i_dbg_brk_ctrl (
    .clk, .rst_n, .host_wr, .host_wdata, .host_rdata, .brk_decoded,
    .halt_fetch, .loop_brk, .sys_reset_req, .ack_valid, .ack_data, .ack_ready
  );

  always @(posedge clk) if (ack_valid && ack_ready) n_bytes++;

  typedef struct packed {
    logic       wr;
    logic [7:0] wd;
    logic       brk;
    logic [7:0] rd;
    logic       rst;
    logic       lp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0},  // R4 strobe while disarmed
    '{1'b1, 8'hFF, 1'b0, 8'hFD, 1'b1, 1'b0},  // R2 R7 bit1 masked, reset pulse
    '{1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b1, 8'h0C, 1'b0, 8'h0C, 1'b0, 1'b0},  // R2 match bits stored
    '{1'b1, 8'h40, 1'b0, 8'h40, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'hC0, 1'b0, 1'b0},  // R5 enter halt
    '{1'b1, 8'h40, 1'b0, 8'h40, 1'b0, 1'b0},  // R3 run command
    '{1'b1, 8'h50, 1'b0, 8'h50, 1'b0, 1'b0},
    '{1'b0, 8'h00, 1'b1, 8'h50, 1'b0, 1'b1},  // R6 loop
    '{1'b1, 8'h81, 1'b0, 8'h81, 1'b1, 1'b0},  // R7 reset and stop
    '{1'b0, 8'h00, 1'b0, 8'h80, 1'b0, 1'b0},
    '{1'b1, 8'h41, 1'b0, 8'h41, 1'b1, 1'b0},  // R7 reset and go
    '{1'b0, 8'h00, 1'b0, 8'h40, 1'b0, 1'b0},
    '{1'b1, 8'h42, 1'b0, 8'h40, 1'b0, 1'b0},  // R2 reserved write
    '{1'b1, 8'h40, 1'b1, 8'hC0, 1'b0, 1'b0},  // R11 halt beats write
    '{1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, capture loop_brk, return at the next negedge
  task automatic step(input logic wr, input logic [7:0] wd, input logic brk);
    host_wr = wr; host_wdata = wd; brk_decoded = brk;
    #1 lp_seen = loop_brk;
    @(negedge clk);
    host_wr = 1'b0; brk_decoded = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int b0;
    repeat (3) @(negedge clk);
    check(host_rdata == 8'h00 && !halt_fetch && !loop_brk && !sys_reset_req && !ack_valid,
          "R1 reset state", {host_rdata, halt_fetch, loop_brk, sys_reset_req, ack_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].wr, VECS[i].wd, VECS[i].brk);
      check(host_rdata == VECS[i].rd, $sformatf("vec%0d rdata R2 R3 R5 R7", i), host_rdata, VECS[i].rd);
      check(halt_fetch == VECS[i].rd[7], $sformatf("vec%0d halt R3", i), halt_fetch, VECS[i].rd[7]);
      check(sys_reset_req == VECS[i].rst, $sformatf("vec%0d reset R7", i), sys_reset_req, VECS[i].rst);
      check(lp_seen == VECS[i].lp, $sformatf("vec%0d loop R6", i), lp_seen, VECS[i].lp);
      check(!ack_valid, $sformatf("vec%0d no ack R4", i), ack_valid, 0);
    end

    // acknowledge with a stalled transmitter
    b0 = n_bytes;
    step(1'b1, 8'h60, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    check(ack_valid && ack_data == 8'hFF, "R8 ack offered", {ack_valid, ack_data}, 9'h1FF);
    check(host_rdata == 8'hE0, "R5 halt with ack", host_rdata, 8'hE0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 8'h00, 1'b0);
      check(ack_valid && ack_data == 8'hFF, "R8 ack held", {ack_valid, ack_data}, 9'h1FF);
    end
    step(1'b0, 8'h00, 1'b1);
    check(ack_valid && ack_data == 8'hFF, "R10 second brk while pending", {ack_valid, ack_data}, 9'h1FF);
    ack_ready = 1'b1;
    step(1'b0, 8'h00, 1'b0);
    check(!ack_valid, "R9 valid dropped", ack_valid, 0);
    check(host_rdata == 8'hC0, "R9 ack enable cleared", host_rdata, 8'hC0);
    step(1'b0, 8'h00, 1'b0);
    check(n_bytes - b0 == 1, "R10 one byte", n_bytes - b0, 1);

    // loop mode burst with ready high
    step(1'b1, 8'h00, 1'b0);
    step(1'b1, 8'h70, 1'b0);
    b0 = n_bytes;
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 8'h00, 1'b1);
      check(lp_seen, "R6 loop burst", lp_seen, 1);
    end
    step(1'b0, 8'h00, 1'b0);
    check(n_bytes - b0 == 1, "R10 one byte in burst", n_bytes - b0, 1);
    check(host_rdata == 8'h50, "R9 R6 word after burst", host_rdata, 8'h50);
    check(!halt_fetch, "R6 no halt in loop", halt_fetch, 0);

    // disarmed with ack enable: nothing happens
    step(1'b1, 8'h20, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    check(!ack_valid && host_rdata == 8'h20, "R4 disarmed ack", {ack_valid, host_rdata}, 9'h020);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule